// File: doc/BRIEF.md
# Receiver Electrical Idle Inference

This block watches the receive side of a PCIe-style link. It decides that the far end has gone into electrical idle when traffic it expects fails to arrive within a time window. It does not rely on an analog squelch detector. The link state machine supplies a 3-bit condition code that selects what to watch for and how long to wait. The link rate sets how a window given in unit intervals maps onto core clock cycles.

Ordered-set decoding delivers three single-cycle strobes in the core clock domain:

- a COM/SKP ordered set arrived;
- a TS1/TS2 ordered set arrived;
- an electrical-idle exit was detected.

A strobe that belongs to the selected condition restarts the window. When the window runs out, the output gives a single-cycle pulse and then stays quiet until the window is restarted. The condition code and the rate are asynchronous, so each is passed through two flops before use.

Top module: `rx_idle_infer`

## Requirements
- R1: When the synchronized condition code has bit 2 clear (codes 000 to 011), the window is inactive and `idle_inferred` never pulses.
- R2: Code 100 pulses `idle_inferred` after `MS128_CLKS` clock cycles without a COM/SKP strobe. A COM/SKP strobe restarts the count from zero.
- R3: Code 101 pulses after ceil(1280 / UI-per-clock) cycles without a TS1/TS2 strobe. UI-per-clock is `UI_PER_CLK_G1` at Gen1 and `UI_PER_CLK_G2` at Gen2.
- R4: Code 110 pulses after a run of cycles with no idle-exit strobe. The run is ceil(2000 / `UI_PER_CLK_G1`) cycles at Gen1 and ceil(16000 / `UI_PER_CLK_G2`) cycles at Gen2.
- R5: Code 111 pulses after `MS128_CLKS` cycles without an idle-exit strobe at Gen1. At Gen2 it never pulses.
- R6: Rate code 00 is Gen1 and rate code 01 is Gen2. Rate codes 10 and 11 make every condition inactive.
- R7: The condition code and the rate each pass through two flops. A change in either one restarts the window from zero.
- R8: Strobes that do not belong to the selected condition have no effect on the window.
- R9: The pulse lasts exactly one cycle. It is not repeated until a restart starts a new window.
- R10: A synchronous active-high reset clears the synchronizers, the window count and the pulse.
- R11: The pulse appears L clock cycles after the clock edge that sampled the restarting strobe, where L is the window length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| infer_sel | input | 3 | Condition code from the link state machine (asynchronous) |
| link_rate | input | 2 | Rate code, 00 = Gen1, 01 = Gen2 (asynchronous) |
| os_comskp_seen | input | 1 | One-cycle strobe: COM/SKP ordered set received |
| os_ts_seen | input | 1 | One-cycle strobe: TS1/TS2 ordered set received |
| eidle_exit_seen | input | 1 | One-cycle strobe: electrical-idle exit detected |
| idle_inferred | output | 1 | One-cycle pulse: electrical idle inferred |

## Verification
The case that is hardest to reach from the ports is a restart that arrives part-way through a window. There are three forms of it: a condition-code change, a rate change, or a reset. In each form the old count must be dropped, with the extra delay of the synchronizer accounted for. The stimulus counts cycles from a known restarting strobe and applies the change at a chosen cycle. It then checks that the pulse lands at that cycle, plus the synchronizer and restart latency, plus the full new window. It must not land where the old window would have ended. The window lengths chosen for simulation do not divide evenly, so round-up errors also show.

// File: rtl/eii_pkg.sv
package eii_pkg;

  localparam logic [2:0] SEL_COMSKP  = 3'b100;
  localparam logic [2:0] SEL_TS      = 3'b101;
  localparam logic [2:0] SEL_EXIT_UI = 3'b110;
  localparam logic [2:0] SEL_EXIT_MS = 3'b111;

  localparam logic [1:0] RATE_G1 = 2'b00;
  localparam logic [1:0] RATE_G2 = 2'b01;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_COMSKP,
    SRC_TS,
    SRC_EXIT
  } src_e;

  function automatic int unsigned ceil_div(input int unsigned num,
                                           input int unsigned den);
    if (den == 0) return 0;
    return (num + den - 1) / den;
  endfunction

  // Window length in clocks; zero means the condition is inactive.
  function automatic int unsigned window_clks(input logic [2:0] sel,
                                              input logic [1:0] rate,
                                              input int unsigned ms_clks,
                                              input int unsigned upc_g1,
                                              input int unsigned upc_g2);
    int unsigned upc;
    if (rate != RATE_G1 && rate != RATE_G2) return 0;
    upc = (rate == RATE_G1) ? upc_g1 : upc_g2;
    case (sel)
      SEL_COMSKP:  return ms_clks;
      SEL_TS:      return ceil_div(1280, upc);
      SEL_EXIT_UI: return (rate == RATE_G1) ? ceil_div(2000, upc) : ceil_div(16000, upc);
      SEL_EXIT_MS: return (rate == RATE_G1) ? ms_clks : 0;
      default:     return 0;
    endcase
  endfunction

  function automatic src_e window_src(input logic [2:0] sel);
    case (sel)
      SEL_COMSKP:               return SRC_COMSKP;
      SEL_TS:                   return SRC_TS;
      SEL_EXIT_UI, SEL_EXIT_MS: return SRC_EXIT;
      default:                  return SRC_NONE;
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned max_window(input int unsigned ms_clks,
                                             input int unsigned upc_g1,
                                             input int unsigned upc_g2);
    int unsigned m;
    m = max2(ms_clks, ceil_div(1280, upc_g1));
    m = max2(m, ceil_div(1280, upc_g2));
    m = max2(m, ceil_div(2000, upc_g1));
    m = max2(m, ceil_div(16000, upc_g2));
    return m;
  endfunction

endpackage

// File: rtl/eii_sync.sv
module eii_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q_sync <= '0;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/eii_window_sel.sv
module eii_window_sel
  import eii_pkg::*;
#(
  parameter int unsigned MS128_CLKS    = 32_000_000,
  parameter int unsigned UI_PER_CLK_G1 = 10,
  parameter int unsigned UI_PER_CLK_G2 = 20,
  parameter int          CNT_W         = 25
) (
  input  logic [2:0]       sel,
  input  logic [1:0]       rate,
  input  logic             comskp_stb,
  input  logic             ts_stb,
  input  logic             exit_stb,
  output logic             active,
  output logic [CNT_W-1:0] limit,
  output logic             qual_hit
);
  int unsigned clks;
  src_e        src;

  always_comb begin
    clks   = window_clks(sel, rate, MS128_CLKS, UI_PER_CLK_G1, UI_PER_CLK_G2);
    src    = window_src(sel);
    active = (clks != 0);
    limit  = CNT_W'(clks);
    case (src)
      SRC_COMSKP: qual_hit = comskp_stb;
      SRC_TS:     qual_hit = ts_stb;
      SRC_EXIT:   qual_hit = exit_stb;
      default:    qual_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/eii_window_cnt.sv
module eii_window_cnt #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             pulse
);
  logic [CNT_W-1:0] limit_m1;
  logic             at_limit;

  assign limit_m1 = limit - 1'b1;
  assign at_limit = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (restart || !active) begin
        cnt <= '0;
      end else if (!at_limit) begin
        cnt <= cnt + 1'b1;
        if (cnt == limit_m1) pulse <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_idle_infer.sv
module rx_idle_infer
  import eii_pkg::*;
#(
  parameter int unsigned MS128_CLKS    = 32_000_000,
  parameter int unsigned UI_PER_CLK_G1 = 10,
  parameter int unsigned UI_PER_CLK_G2 = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] infer_sel,
  input  logic [1:0] link_rate,
  input  logic       os_comskp_seen,
  input  logic       os_ts_seen,
  input  logic       eidle_exit_seen,
  output logic       idle_inferred
);
  localparam int unsigned MAX_LIM = max_window(MS128_CLKS, UI_PER_CLK_G1, UI_PER_CLK_G2);
  localparam int          CNT_W   = $clog2(MAX_LIM + 1);

  logic [4:0]       cfg_async;
  logic [4:0]       cfg_sync;
  logic [4:0]       cfg_q;
  logic [2:0]       sel_sync;
  logic [1:0]       rate_sync;
  logic             cfg_chg;
  logic             qual_hit;
  logic             win_active;
  logic [CNT_W-1:0] win_limit;
  logic [CNT_W-1:0] win_cnt;
  logic             win_restart;

  assign cfg_async = {infer_sel, link_rate};

  eii_sync #(.W(5)) u_cfg_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (cfg_async),
    .q_sync  (cfg_sync)
  );

  assign sel_sync  = cfg_sync[4:2];
  assign rate_sync = cfg_sync[1:0];

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_sync;
  end

  assign cfg_chg = (cfg_q != cfg_sync);

  eii_window_sel #(
    .MS128_CLKS    (MS128_CLKS),
    .UI_PER_CLK_G1 (UI_PER_CLK_G1),
    .UI_PER_CLK_G2 (UI_PER_CLK_G2),
    .CNT_W         (CNT_W)
  ) u_sel (
    .sel        (sel_sync),
    .rate       (rate_sync),
    .comskp_stb (os_comskp_seen),
    .ts_stb     (os_ts_seen),
    .exit_stb   (eidle_exit_seen),
    .active     (win_active),
    .limit      (win_limit),
    .qual_hit   (qual_hit)
  );

  assign win_restart = cfg_chg | qual_hit;

  eii_window_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .active  (win_active),
    .restart (win_restart),
    .limit   (win_limit),
    .cnt     (win_cnt),
    .pulse   (idle_inferred)
  );
endmodule

// File: rtl/eii_checker.sv
module eii_checker #(
  parameter int CNT_W = 25
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       rate_sync,
  input logic             cfg_chg,
  input logic             qual_hit,
  input logic             win_active,
  input logic [CNT_W-1:0] win_limit,
  input logic [CNT_W-1:0] win_cnt,
  input logic             idle_inferred
);
  p_off_never_flags_r1: assert property (@(posedge clk) disable iff (rst)
    !win_active |=> !idle_inferred);

  p_strobe_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (qual_hit && win_active) |=> (win_cnt == '0));

  p_bad_rate_off_r6: assert property (@(posedge clk) disable iff (rst)
    rate_sync[1] |-> !win_active);

  p_cfg_restart_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> (win_cnt == '0));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    idle_inferred |=> !idle_inferred);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (win_active && !cfg_chg) |-> (win_cnt <= win_limit));

  p_pulse_at_limit_r11: assert property (@(posedge clk) disable iff (rst)
    idle_inferred |-> ($past(win_cnt) == $past(win_limit) - 1'b1));

  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (win_cnt == '0 && !idle_inferred));
endmodule

bind rx_idle_infer eii_checker #(.CNT_W(CNT_W)) u_eii_chk (
  .clk           (clk),
  .rst           (rst),
  .rate_sync     (rate_sync),
  .cfg_chg       (cfg_chg),
  .qual_hit      (qual_hit),
  .win_active    (win_active),
  .win_limit     (win_limit),
  .win_cnt       (win_cnt),
  .idle_inferred (idle_inferred)
);

// File: tb/test_rx_idle_infer.sv
module test_rx_idle_infer;
  localparam int unsigned T_MS  = 200;
  localparam int unsigned T_G1  = 12;
  localparam int unsigned T_G2  = 24;
  localparam int          NVEC  = 12;

  // {code, rate, expected window in cycles (0 = never)}
  localparam logic [16:0] VEC [NVEC] = '{
    {3'b100, 2'b00, 12'd200}, {3'b100, 2'b01, 12'd200},
    {3'b101, 2'b00, 12'd107}, {3'b101, 2'b01, 12'd54},
    {3'b110, 2'b00, 12'd167}, {3'b110, 2'b01, 12'd667},
    {3'b111, 2'b00, 12'd200}, {3'b111, 2'b01, 12'd0},
    {3'b000, 2'b00, 12'd0},   {3'b011, 2'b01, 12'd0},
    {3'b100, 2'b10, 12'd0},   {3'b101, 2'b11, 12'd0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = 3'b000;
  logic [1:0] rate = 2'b00;
  logic       comskp = 1'b0;
  logic       ts = 1'b0;
  logic       ex = 1'b0;
  logic       idle;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rx_idle_infer #(
    .MS128_CLKS    (T_MS),
    .UI_PER_CLK_G1 (T_G1),
    .UI_PER_CLK_G2 (T_G2)
  ) i_rx_idle_infer (
    .clk             (clk),
    .rst             (rst),
    .infer_sel       (sel),
    .link_rate       (rate),
    .os_comskp_seen  (comskp),
    .os_ts_seen      (ts),
    .eidle_exit_seen (ex),
    .idle_inferred   (idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] s, input logic [1:0] r);
    if (r[1])       return "R6";
    if (!s[2])      return "R1";
    if (s == 3'b100) return "R2";
    if (s == 3'b101) return "R3";
    if (s == 3'b110) return "R4";
    return "R5";
  endfunction

  task automatic drive_qual(input logic [2:0] s);
    case (s)
      3'b100:         comskp = 1'b1;
      3'b101:         ts = 1'b1;
      3'b110, 3'b111: ex = 1'b1;
      default: begin comskp = 1'b1; ts = 1'b1; ex = 1'b1; end
    endcase
  endtask

  // ev_kind: 0 none, 1 qualifying strobe, 2 code change, 3 reset, 4 rate change
  task automatic run_case(input logic [2:0] s, input logic [1:0] r, input int exp,
                          input bit noise, input int ev_at, input int ev_kind,
                          input logic [2:0] ev_sel, input logic [1:0] ev_rate,
                          input string req);
    int first;
    int hits;
    int win;
    first = -1;
    hits  = 0;
    win   = (exp > 0 ? exp : 600) + 40;
    @(negedge clk);
    sel = s; rate = r; comskp = 0; ts = 0; ex = 0;
    repeat (4) @(negedge clk);
    drive_qual(s);
    @(negedge clk);
    comskp = 0; ts = 0; ex = 0;
    for (int n = 1; n <= win; n++) begin
      @(negedge clk);
      if (idle) begin
        if (first < 0) first = n;
        hits++;
      end
      comskp = 0; ts = 0; ex = 0; rst = 0;
      if (noise && (n % 20 == 0)) begin
        if (s != 3'b100) comskp = 1'b1;
        if (s != 3'b101) ts = 1'b1;
        if (s[2:1] != 2'b11) ex = 1'b1;
      end
      if (n == ev_at) begin
        case (ev_kind)
          1: drive_qual(s);
          2: sel = ev_sel;
          3: rst = 1'b1;
          4: rate = ev_rate;
          default: ;
        endcase
      end
    end
    if (exp == 0) begin
      chk(hits == 0, req, hits, 0);
    end else begin
      chk(first == exp, req, first, exp);
      chk(hits == 1, "R9", hits, 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=timeout expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    sel = 3'b101; rate = 2'b00;
    repeat (5) @(negedge clk);
    // R10: outputs held clear during reset
    chk(idle == 1'b0, "R10", idle, 0);
    rst = 1'b0;

    // Table walk: windows per code and rate (R1..R6, R11)
    for (int i = 0; i < NVEC; i++) begin
      run_case(VEC[i][16:14], VEC[i][13:12], int'(VEC[i][11:0]), 1'b0, 0, 0,
               3'b000, 2'b00, req_of(VEC[i][16:14], VEC[i][13:12]));
    end

    // R8: foreign strobes every 20 cycles do not disturb the TS window
    run_case(3'b101, 2'b00, 107, 1'b1, 0, 0, 3'b000, 2'b00, "R8");
    // R8: same for the COM/SKP window at Gen2
    run_case(3'b100, 2'b01, 200, 1'b1, 0, 0, 3'b000, 2'b00, "R8");
    // R2/R11: qualifying strobe at cycle 150 restarts: 150+1+200
    run_case(3'b100, 2'b00, 351, 1'b0, 150, 1, 3'b000, 2'b00, "R2");
    // R7: code change at cycle 50 -> 50 + 3 (sync, restart) + 167
    run_case(3'b101, 2'b00, 220, 1'b0, 50, 2, 3'b110, 2'b00, "R7");
    // R7: rate change at cycle 100 -> 100 + 3 + 667
    run_case(3'b110, 2'b00, 770, 1'b0, 100, 4, 3'b000, 2'b01, "R7");
    // R10: reset at cycle 100 -> 100 + 4 (reset, sync refill, restart) + 200
    run_case(3'b100, 2'b00, 304, 1'b0, 100, 3, 3'b000, 2'b00, "R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule